// File: doc/BRIEF.md
# Prioritized Sensor Fault Monitor

This block watches four sensor event lines and raises one fault flag. In the event vector a 1 means the sensor reports an event and a 0 means it is quiet. Bit 0 is a high-priority sensor: an event on it raises the fault on its own. The other three bits are low-priority. Bit 1 is a single sensor. Bits 2 and 3 are a redundant pair that watch the same condition, so one or both of them active counts as exactly one distinct event. The fault rises when at least two distinct low-priority events occur together, that is when bit 1 is active together with either member of the pair.

The decode is a two-level sum of products, `s0 | s1·s2 | s1·s3`. A parameter places a two-flop synchronizer in front of it, so the sensor lines may be asynchronous to the clock. A second parameter registers the flag on the rising edge. Every flop clears asynchronously on an active-low reset. With both options on, which is the default, a change on the sensor lines reaches the fault output on the third rising edge.

Top module: `sensor_fault_mon`

## Requirements
- R1: When bit 0 of `sense_i` is 1, the fault output is 1 whatever the other bits are.
- R2: When bit 1 is 1 and at least one of bits 2 or 3 is 1, the fault output is 1.
- R3: When bit 0 and bit 1 are both 0, the fault is 0 whatever the pair (bits 2 and 3) does. This includes pattern 1100 (MSB first), where both members of the pair are active.
- R4: When bit 1 is the only active bit (pattern 0010), the fault is 0.
- R5: When no bit is active (pattern 0000), the fault is 0.
- R6: While `rst_ni` is 0, the fault output is 0, and it clears at once when reset is asserted, without waiting for a clock edge.
- R7: With the default configuration (two synchronizer stages and a registered output), a change of `sense_i` shows at `fault_o` after exactly three rising edges. After two edges the output still shows the previous result.
- R8: For all 16 input codes, the fault equals bit 0 OR (the count of distinct low-priority events, with bit 1 as one source and the merged pair as the other, is at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_i | input | 4 | Sensor events: bit 0 high-priority, bit 1 single low-priority, bits 2 and 3 redundant pair |
| fault_o | output | 1 | Fault flag |

## Verification
On every cycle the assertions check three things. The high-priority bit forces the decoded fault. A vector with bits 0 and 1 both clear never decodes to a fault. The product-term decode agrees with the event count kept in a separate function. They also check that each synchronizer stage and the output register copy their predecessor one edge later. Only the bench's scenarios can show the end-to-end function at the ports for every one of the 16 codes, the exact three-edge latency including the unchanged output after two edges, and the asynchronous clearing of the flag in the middle of a cycle.

// File: rtl/sensor_fault_pkg.sv
package sensor_fault_pkg;

  localparam int unsigned SENSE_W = 4;
  localparam int unsigned HI_BIT = 0;
  localparam int unsigned LO_BIT = 1;
  localparam int unsigned PAIR_A = 2;
  localparam int unsigned PAIR_B = 3;
  localparam int unsigned LO_THRESH = 2;

  typedef logic [SENSE_W-1:0] sense_t;
  typedef logic [1:0] evcnt_t;

  // distinct low-priority events: the single sensor plus the merged pair
  function automatic evcnt_t low_events(input sense_t s);
    evcnt_t n;
    n = '0;
    if (s[LO_BIT]) n = n + evcnt_t'(1);
    if (s[PAIR_A] || s[PAIR_B]) n = n + evcnt_t'(1);
    return n;
  endfunction

  function automatic logic fault_by_count(input sense_t s);
    return s[HI_BIT] || (low_events(s) >= evcnt_t'(LO_THRESH));
  endfunction

endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg <= '0;
        end else begin
          stg[0] <= d_i;
          for (int i = 1; i < int'(STAGES); i++) begin
            stg[i] <= stg[i-1];
          end
        end
      end

      assign q_o = stg[STAGES-1];

      if (STAGES >= 2) begin : g_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
          stg[1] == $past(stg[0])); // R7
      end
    end
  endgenerate

endmodule

// File: rtl/fault_decode.sv
module fault_decode
  import sensor_fault_pkg::*;
(
  input  sense_t ev_i,
  output logic   pair_hit_o,
  output evcnt_t low_cnt_o,
  output logic   fault_o
);

  localparam int unsigned N_TERMS = 3;

  logic [N_TERMS-1:0] term;

  // minimal sum of products: hi | lo&pairA | lo&pairB
  assign term[0] = ev_i[HI_BIT];
  assign term[1] = ev_i[LO_BIT] & ev_i[PAIR_A];
  assign term[2] = ev_i[LO_BIT] & ev_i[PAIR_B];

  assign fault_o    = |term;
  assign pair_hit_o = ev_i[PAIR_A] | ev_i[PAIR_B];
  assign low_cnt_o  = low_events(ev_i);

endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  generate
    if (ENABLE) begin : g_reg
      logic q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= 1'b0;
        else         q_r <= d_i;
      end
      assign q_o = q_r;

      AST_FLAG_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> q_o == $past(d_i)); // R7
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/sensor_fault_mon.sv
module sensor_fault_mon
  import sensor_fault_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          OUT_REG     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sense_i,
  output logic       fault_o
);

  localparam int unsigned LATENCY = SYNC_STAGES + (OUT_REG ? 1 : 0);

  sense_t dec_in;
  logic   pair_hit;
  evcnt_t low_cnt;
  logic   dec_fault;

  sense_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sense_i),
    .q_o   (dec_in)
  );

  fault_decode u_dec (
    .ev_i      (dec_in),
    .pair_hit_o(pair_hit),
    .low_cnt_o (low_cnt),
    .fault_o   (dec_fault)
  );

  flag_reg #(.ENABLE(OUT_REG)) u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dec_fault),
    .q_o   (fault_o)
  );

  AST_HIPRI_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_in[HI_BIT] |-> dec_fault); // R1

  AST_PAIR_ALONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_in[HI_BIT] && !dec_in[LO_BIT]) |-> !dec_fault); // R3

  AST_PAIR_MERGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_in[LO_BIT] && pair_hit) |-> dec_fault); // R2

  AST_SOP_MATCHES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_fault == (dec_in[HI_BIT] || low_cnt >= evcnt_t'(LO_THRESH))); // R8

  initial begin
    AST_LATENCY_SANE: assert (LATENCY <= 8); // R7
  end

endmodule

// File: tb/sensor_fault_mon_test.sv
module sensor_fault_mon_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sense = 4'b0000;
  logic       fault;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sensor_fault_mon uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sense_i(sense),
    .fault_o(fault)
  );

  // reference: high bit, or two distinct low-priority sources by population count
  function automatic bit ref_fault(input logic [3:0] s);
    int pc;
    pc = $countones({s[1], s[2] | s[3]});
    return s[0] || (pc >= 2);
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s[0])                 return "R1";
    if (s[1] && (s[2] | s[3])) return "R2";
    if (s == 4'b0000)         return "R5";
    if (s == 4'b0010)         return "R4";
    return "R3";
  endfunction

  task automatic check(input logic got, input logic exp, input string tag,
                       input logic [3:0] s);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s sense=%b got=%b expected=%b", tag, s, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, inout logic prev);
    logic e;
    e = ref_fault(s);
    @(negedge clk) sense = s;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) check(fault, prev, "R7 early", s);
    @(posedge clk);
    @(negedge clk) begin
      check(fault, e, "R8", s);
      check(fault, e, req_of(s), s);
    end
    prev = e;
  endtask

  initial begin
    logic prev;
    // R6: held in reset with the high-priority input active
    sense = 4'b0001;
    repeat (4) @(posedge clk);
    @(negedge clk) check(fault, 1'b0, "R6 reset", sense);
    sense = 4'b0000;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) check(fault, 1'b0, "R5 idle", sense);
    prev = 1'b0;

    for (int v = 0; v < 16; v++) apply(4'(v), prev);
    for (int v = 15; v >= 0; v--) apply(4'(v ^ (v >> 1)), prev);
    apply(4'b1100, prev); // R3 pair alone
    apply(4'b0001, prev); // R1
    apply(4'b0010, prev); // R4
    apply(4'b1010, prev); // R2

    // R6: asynchronous clear mid-cycle
    apply(4'b0001, prev);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check(fault, 1'b0, "R6 async", sense);
    @(negedge clk) check(fault, 1'b0, "R6 held", sense);
    sense = 4'b0000;
    rst_n = 1'b1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule